// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block schedules auto-refresh for a four-bank DDR memory controller. It counts controller clocks and adds one refresh obligation per refresh interval to a debt counter. While the debt is non-zero and every bank is precharged, it raises a request to the command arbiter. Each grant pays back one unit of debt and starts a refresh-cycle-time window, during which the device takes no other command. This lets refreshes be postponed while the command path is busy. When the debt reaches the burst limit of eight, the block flags the request as urgent, and the arbiter must then stop opening rows.

The block also controls self-refresh. On an entry request, taken only while all banks are precharged and no timing window is open, it drops the clock-enable and issues a one-cycle entry command strobe. This entry clears the debt and freezes the interval counter. On an exit request it raises the clock-enable again and times two separate wake-up windows, one for non-read commands and a longer one for reads. The interval counter starts again from zero at exit.

All timing values are given in picoseconds, or in clocks for the read wake-up. The block turns them into clock counts by rounding up against the clock period.

Top module: `refresh_scheduler`

## Requirements
- R1: After reset, refReq, refUrgent, refBusy and srEntryCmd are 0, refDebt is 0, and ckeOut, nonReadOk and readOk are 1.
- R2: While not in self-refresh, refDebt grows by one every ceil(REFI_PS/CLK_PS) clocks. The first increment comes that many clocks after reset or after self-refresh exit.
- R3: refDebt never exceeds MAX_DEBT (8). refUrgent is 1 exactly when refDebt equals MAX_DEBT. A new interval that arrives at the limit is dropped, unless a grant is taken in the same cycle.
- R4: refReq rises only in the cycle after one in which refDebt was non-zero, allPrecharged was 1, refBusy was 0, nonReadOk was 1 and the block was not in self-refresh. Once raised it stays high until granted or until self-refresh entry, even if allPrecharged falls.
- R5: A cycle with refGrant and refReq both high is a taken grant. It drops refReq and lowers refDebt by one at the next edge. refGrant with refReq low has no effect.
- R6: After a taken grant, refBusy is 1 for exactly ceil(RFC_PS/CLK_PS) cycles, and refReq is not raised during that window.
- R7: Self-refresh entry is accepted when srEnterReq and allPrecharged are 1, refBusy is 0 and nonReadOk is 1. At the next edge ckeOut goes low, srEntryCmd pulses for one cycle, refDebt becomes 0 and refReq drops.
- R8: While ckeOut is low, refDebt stays 0, refReq stays 0, and nonReadOk and readOk are 0.
- R9: srExitReq while in self-refresh sets ckeOut at the next edge. nonReadOk then stays 0 for ceil(XSNR_PS/CLK_PS) cycles, and readOk stays 0 for XSRD_CK cycles.
- R10: With CLK_PS=7500, RFC_PS=72000 and XSNR_PS=75000, both windows last 10 cycles, because the fractional count is rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allPrecharged | input | 1 | All four banks are in the precharged state |
| refGrant | input | 1 | Arbiter grants the pending refresh request |
| srEnterReq | input | 1 | Request to enter self-refresh |
| srExitReq | input | 1 | Request to leave self-refresh |
| refReq | output | 1 | Refresh request to the arbiter |
| refUrgent | output | 1 | Debt at limit; block new row activates |
| refDebt | output | $clog2(MAX_DEBT+1) | Refreshes currently owed |
| refBusy | output | 1 | Refresh cycle time still running |
| ckeOut | output | 1 | Clock-enable to the device |
| srEntryCmd | output | 1 | One-cycle strobe: issue refresh command with CKE low |
| nonReadOk | output | 1 | Non-read commands allowed |
| readOk | output | 1 | Read commands allowed |

## Verification
Every result is registered, so a stimulus applied before a rising edge shows at the outputs just after that edge. The interval tick moves refDebt one edge after the counter's last count. The grant updates refReq, refDebt and refBusy one edge later, and the entry and exit requests change ckeOut and the wake-up flags one edge later. The bench drives inputs at the falling edge. It advances a reference model at each rising edge, written from the requirements, and compares every output at the following falling edge. Directed runs count the refBusy window, the two wake-up windows and the debt after exit in whole cycles and compare them with the rounded-up counts.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_SELF = 1'b1
  } mode_e;

  // control -> datapath
  typedef struct packed {
    logic take;     // grant accepted this cycle
    logic srEnter;  // self-refresh entry accepted
    logic srExit;   // self-refresh exit accepted
    logic holdIv;   // hold interval counter at zero
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic debtNz;
    logic rfcIdle;
    logic xsnrIdle;
    logic xsrdIdle;
  } tmrStatus_t;

  function automatic int cyclesUp(int ps, int clkPs);
    return (ps + clkPs - 1) / clkPs;
  endfunction

endpackage

// File: rtl/refsched_delay.sv
module refsched_delay #(
  parameter int LOAD = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic idle
);
  localparam int W = $clog2(LOAD + 1);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (load)        cnt <= LOAD_V;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/refsched_timers.sv
module refsched_timers
  import refsched_pkg::*;
#(
  parameter int REFI_CYC = 1040,
  parameter int RFC_CYC  = 10,
  parameter int XSNR_CYC = 10,
  parameter int XSRD_CYC = 200,
  parameter int MAX_DEBT = 8,
  parameter int DEBT_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  output tmrStatus_t        stat,
  output logic [DEBT_W-1:0] debt
);
  localparam int IV_W = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam logic [IV_W-1:0]   IV_LAST  = IV_W'(REFI_CYC - 1);
  localparam logic [DEBT_W-1:0] DEBT_MAX = DEBT_W'(MAX_DEBT);

  logic [IV_W-1:0] ivCnt;
  logic            tick;
  logic            addOne;
  logic [DEBT_W-1:0] debtNext;

  // interval counter: one obligation per wrap, frozen in self-refresh
  assign tick = !strb.holdIv && !strb.srEnter && (ivCnt == IV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 ivCnt <= '0;
    else if (strb.holdIv || strb.srEnter || tick) ivCnt <= '0;
    else                                       ivCnt <= ivCnt + 1'b1;
  end

  // debt counter, saturating at the burst limit
  always_comb begin
    addOne   = tick && ((debt != DEBT_MAX) || strb.take);
    debtNext = debt + DEBT_W'(addOne) - DEBT_W'(strb.take);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             debt <= '0;
    else if (strb.srEnter) debt <= '0;
    else                   debt <= debtNext;
  end

  // the three timing windows share one countdown structure
  logic rfcIdle, xsnrIdle, xsrdIdle;

  refsched_delay #(.LOAD(RFC_CYC)) rfcWin (
    .clk(clk), .rstN(rstN), .load(strb.take), .idle(rfcIdle));

  refsched_delay #(.LOAD(XSNR_CYC)) xsnrWin (
    .clk(clk), .rstN(rstN), .load(strb.srExit), .idle(xsnrIdle));

  refsched_delay #(.LOAD(XSRD_CYC)) xsrdWin (
    .clk(clk), .rstN(rstN), .load(strb.srExit), .idle(xsrdIdle));

  assign stat.debtNz   = (debt != '0);
  assign stat.rfcIdle  = rfcIdle;
  assign stat.xsnrIdle = xsnrIdle;
  assign stat.xsrdIdle = xsrdIdle;
endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       allPrecharged,
  input  logic       refGrant,
  input  logic       srEnterReq,
  input  logic       srExitReq,
  input  tmrStatus_t stat,
  output ctlStrobe_t strb,
  output logic       refReq,
  output logic       ckeOut,
  output logic       srEntryCmd,
  output logic       nonReadOk,
  output logic       readOk
);
  mode_e mode;
  logic  reqQ;
  logic  entryQ;
  logic  inRun, enter, exitNow, take, raise;

  always_comb begin
    inRun   = (mode == MODE_RUN);
    enter   = inRun && srEnterReq && allPrecharged && stat.rfcIdle && stat.xsnrIdle;
    exitNow = !inRun && srExitReq;
    take    = refGrant && reqQ && !enter;
    raise   = inRun && stat.debtNz && allPrecharged && stat.rfcIdle && stat.xsnrIdle;
    strb    = '{take: take, srEnter: enter, srExit: exitNow, holdIv: !inRun};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= MODE_RUN;
      reqQ   <= 1'b0;
      entryQ <= 1'b0;
    end else begin
      entryQ <= enter;
      if (enter)        mode <= MODE_SELF;
      else if (exitNow) mode <= MODE_RUN;
      if (enter || take) reqQ <= 1'b0;
      else if (raise)    reqQ <= 1'b1;
    end
  end

  assign refReq     = reqQ;
  assign srEntryCmd = entryQ;
  assign ckeOut     = inRun;
  assign nonReadOk  = inRun && stat.xsnrIdle;
  assign readOk     = inRun && stat.xsrdIdle;
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int CLK_PS   = 7500,
  parameter int REFI_PS  = 7800000,
  parameter int RFC_PS   = 75000,
  parameter int XSNR_PS  = 75000,
  parameter int XSRD_CK  = 200,
  parameter int MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic allPrecharged,
  input  logic refGrant,
  input  logic srEnterReq,
  input  logic srExitReq,
  output logic refReq,
  output logic refUrgent,
  output logic [$clog2(MAX_DEBT+1)-1:0] refDebt,
  output logic refBusy,
  output logic ckeOut,
  output logic srEntryCmd,
  output logic nonReadOk,
  output logic readOk
);
  localparam int DEBT_W   = $clog2(MAX_DEBT + 1);
  localparam int REFI_CYC = cyclesUp(REFI_PS, CLK_PS);
  localparam int RFC_CYC  = cyclesUp(RFC_PS, CLK_PS);
  localparam int XSNR_CYC = cyclesUp(XSNR_PS, CLK_PS);
  localparam logic [DEBT_W-1:0] DEBT_MAX = DEBT_W'(MAX_DEBT);

  ctlStrobe_t strb;
  tmrStatus_t stat;

  refsched_timers #(
    .REFI_CYC(REFI_CYC), .RFC_CYC(RFC_CYC), .XSNR_CYC(XSNR_CYC),
    .XSRD_CYC(XSRD_CK), .MAX_DEBT(MAX_DEBT), .DEBT_W(DEBT_W)
  ) tmr (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat), .debt(refDebt));

  refsched_ctrl ctl (
    .clk(clk), .rstN(rstN), .allPrecharged(allPrecharged), .refGrant(refGrant),
    .srEnterReq(srEnterReq), .srExitReq(srExitReq), .stat(stat), .strb(strb),
    .refReq(refReq), .ckeOut(ckeOut), .srEntryCmd(srEntryCmd),
    .nonReadOk(nonReadOk), .readOk(readOk));

  assign refUrgent = (refDebt == DEBT_MAX);
  assign refBusy   = !stat.rfcIdle;
endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk #(
  parameter int MAX_DEBT = 8
) (
  input logic clk,
  input logic rstN,
  input logic allPrecharged,
  input logic refGrant,
  input logic srEnterReq,
  input logic srExitReq,
  input logic refReq,
  input logic refUrgent,
  input logic [$clog2(MAX_DEBT+1)-1:0] refDebt,
  input logic refBusy,
  input logic ckeOut,
  input logic srEntryCmd,
  input logic nonReadOk,
  input logic readOk
);
  localparam int DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] LIMIT = DW'(MAX_DEBT);

  // R3
  debt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    refDebt <= LIMIT);

  // R3
  urgent_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent && !refGrant && !srEnterReq |=> refUrgent);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq && !refGrant && !srEnterReq |=> refReq);

  // R4
  req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refReq) |-> $past(allPrecharged) && $past(ckeOut));

  // R5
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq && refGrant && !srEnterReq |=> !refReq && refBusy);

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    refBusy && !refReq |=> !refReq);

  // R7
  entry_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    srEntryCmd |-> !ckeOut && refDebt == '0 && !refReq);

  // R8
  self_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ckeOut |-> !refReq && !nonReadOk && !readOk);

  // R9
  exit_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ckeOut && srExitReq |=> ckeOut && !nonReadOk && !readOk);
endmodule

bind refresh_scheduler refresh_scheduler_chk #(.MAX_DEBT(MAX_DEBT)) chkInst (.*);

// File: tb/refresh_scheduler_test.sv
`timescale 1ns/1ps
module refresh_scheduler_test;
  localparam int CLK_NS   = 10;
  localparam int CLK_PS   = 7500;
  localparam int REFI_PS  = 300000;  // 40 cycles
  localparam int RFC_PS   = 72000;   // 9.6 -> 10 cycles
  localparam int XSNR_PS  = 75000;   // 10 cycles
  localparam int XSRD_CK  = 200;
  localparam int MAX_DEBT = 8;
  localparam int REFI_C   = 40;
  localparam int RFC_C    = 10;
  localparam int XSNR_C   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allPrecharged = 1'b0, refGrant = 1'b0, srEnterReq = 1'b0, srExitReq = 1'b0;
  logic refReq, refUrgent, refBusy, ckeOut, srEntryCmd, nonReadOk, readOk;
  logic [3:0] refDebt;

  int tests = 0;
  int fails = 0;

  // reference model state
  int mIv, mDebt, mRfc, mXsnr, mXsrd;
  bit mReq, mSr, mCmd;

  always #(CLK_NS/2) clk = ~clk;

  refresh_scheduler #(
    .CLK_PS(CLK_PS), .REFI_PS(REFI_PS), .RFC_PS(RFC_PS),
    .XSNR_PS(XSNR_PS), .XSRD_CK(XSRD_CK), .MAX_DEBT(MAX_DEBT)
  ) uut (.*);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIv = 0; mDebt = 0; mRfc = 0; mXsnr = 0; mXsrd = 0;
      mReq = 0; mSr = 0; mCmd = 0;
    end else begin
      bit enter, leave, take, tick, raise;
      enter = !mSr && srEnterReq && allPrecharged && mRfc == 0 && mXsnr == 0;
      leave = mSr && srExitReq;
      take  = refGrant && mReq && !enter;
      tick  = !mSr && !enter && mIv == REFI_C - 1;
      raise = !mSr && mDebt != 0 && allPrecharged && mRfc == 0 && mXsnr == 0;
      mIv   = (mSr || enter || tick) ? 0 : mIv + 1;
      if (enter) mDebt = 0;
      else mDebt = mDebt + ((tick && (mDebt < MAX_DEBT || take)) ? 1 : 0) - (take ? 1 : 0);
      mRfc  = take ? RFC_C : (mRfc > 0 ? mRfc - 1 : 0);
      mXsnr = leave ? XSNR_C : (mXsnr > 0 ? mXsnr - 1 : 0);
      mXsrd = leave ? XSRD_CK : (mXsrd > 0 ? mXsrd - 1 : 0);
      if (enter || take) mReq = 0; else if (raise) mReq = 1;
      mCmd = enter;
      if (enter) mSr = 1; else if (leave) mSr = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R4", "refReq", int'(refReq), int'(mReq));
    chk("R2", "refDebt", int'(refDebt), mDebt);
    chk("R3", "refUrgent", int'(refUrgent), (mDebt == MAX_DEBT) ? 1 : 0);
    chk("R6", "refBusy", int'(refBusy), (mRfc != 0) ? 1 : 0);
    chk("R7", "ckeOut", int'(ckeOut), mSr ? 0 : 1);
    chk("R7", "srEntryCmd", int'(srEntryCmd), int'(mCmd));
    chk("R9", "nonReadOk", int'(nonReadOk), (!mSr && mXsnr == 0) ? 1 : 0);
    chk("R9", "readOk", int'(readOk), (!mSr && mXsrd == 0) ? 1 : 0);
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, nr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "refReq", int'(refReq), 0);
    chk("R1", "refDebt", int'(refDebt), 0);
    chk("R1", "refBusy", int'(refBusy), 0);
    chk("R1", "ckeOut", int'(ckeOut), 1);
    chk("R1", "readOk", int'(readOk), 1);
    chk("R1", "nonReadOk", int'(nonReadOk), 1);
    rstN = 1'b1;

    // R2/R3: banks never precharged, debt climbs and saturates
    repeat (9 * REFI_C + 5) cycle();
    chk("R3", "saturated debt", int'(refDebt), MAX_DEBT);
    chk("R3", "urgent at limit", int'(refUrgent), 1);
    // R5: grant without request is ignored
    refGrant = 1'b1; cycle(); refGrant = 1'b0;
    chk("R5", "stray grant debt", int'(refDebt), MAX_DEBT);

    // R4/R5/R6/R10: single grant, measure busy window
    allPrecharged = 1'b1;
    n = 0;
    while (!refReq && n < 20) begin n++; cycle(); end
    allPrecharged = 1'b0;
    repeat (3) cycle();
    chk("R4", "request held without precharge", int'(refReq), 1);
    refGrant = 1'b1; cycle(); refGrant = 1'b0;
    chk("R5", "debt after grant", int'(refDebt), MAX_DEBT - 1);
    n = 0;
    while (refBusy && n < 100) begin n++; cycle(); end
    chk("R10", "busy window cycles", n, RFC_C);
    chk("R6", "busy window cycles", n, RFC_C);

    // drain with continuous grants
    allPrecharged = 1'b1; refGrant = 1'b1;
    repeat (120) cycle();

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      allPrecharged = ($urandom_range(0, 3) != 0);
      refGrant      = ($urandom_range(0, 1) != 0);
      srEnterReq    = ($urandom_range(0, 199) == 0);
      srExitReq     = ($urandom_range(0, 29) == 0);
      cycle();
    end
    srEnterReq = 1'b0; srExitReq = 1'b1;
    cycle();
    srExitReq = 1'b0;
    repeat (XSRD_CK + 5) cycle();

    // directed self-refresh entry / exit
    allPrecharged = 1'b1; refGrant = 1'b0;
    repeat (3 * REFI_C) cycle();
    srEnterReq = 1'b1;
    n = 0;
    while (ckeOut && n < 40) begin n++; cycle(); end
    srEnterReq = 1'b0;
    chk("R7", "entry strobe", int'(srEntryCmd), 1);
    chk("R7", "debt cleared", int'(refDebt), 0);
    allPrecharged = 1'b0;
    repeat (5 * REFI_C) cycle();
    chk("R8", "debt frozen in self-refresh", int'(refDebt), 0);
    chk("R8", "no request in self-refresh", int'(refReq), 0);
    srExitReq = 1'b1; cycle(); srExitReq = 1'b0;
    chk("R9", "cke after exit", int'(ckeOut), 1);
    n = 0; nr = 0;
    while (!readOk && n < 1000) begin
      if (!nonReadOk) nr++;
      n++;
      cycle();
    end
    chk("R9", "read wait cycles", n, XSRD_CK);
    chk("R10", "non-read wait cycles", nr, XSNR_C);
    chk("R2", "interval restarted at exit", int'(refDebt), XSRD_CK / REFI_C);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule